// File: doc/BRIEF.md
# Modem Status Change Tracker with Loopback

This block keeps the modem line status of a serial port together with its 5-bit modem control register. In live operation it takes the four already-synchronized modem input lines once per clock: carrier detect, ring indicator, data-set-ready and clear-to-send. It stores their current levels in the upper nibble of the status register. Each line that changes also sets a sticky change flag in the lower nibble. The ring indicator is the exception: its flag records only the trailing edge, where the line falls from 1 to 0.

A read of the status register returns all eight bits and clears the change flags in the same cycle. The line levels stay. If a new change arrives in the cycle of the read, its flag is kept. The control register drives the data-terminal-ready, request-to-send and two general-purpose outputs. It also holds a loopback bit that moves the block between two states of a small mode machine:

- **MODE_LIVE**: the default after reset.
- **MODE_LOOP**: the status read shows the control outputs in place of the line levels. The external handshake outputs go inactive, and the input lines are ignored.

The transitions are:

- **LIVE->LOOP**: a control write with bit 4 set.
- **LOOP->LIVE**: a control write with bit 4 clear.
- Any other control write keeps the current state.

A single flag output tells the interrupt logic whether any change flag is pending.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status register reads 0xB0, the control register reads 0x08 and `delta_any` is 0.
- R2: In MODE_LIVE, one clock after an input line changes, the status read shows the new level in the upper nibble. The matching change flag is set and stays set until cleared: carrier on bit 3 (level on bit 7), data-set-ready on bit 1 (level on bit 5), clear-to-send on bit 0 (level on bit 4).
- R3: The ring flag (bit 2, level on bit 6) is set only when the ring level goes from 1 to 0. A 0-to-1 change leaves it clear.
- R4: A status read (`reg_sel`=1, `reg_rd`=1) in MODE_LIVE returns {levels, flags} and clears bits 3:0 at that clock edge. Bits 7:4 are kept.
- R5: In MODE_LOOP a status read returns OUT2 (control bit 3) on bit 7, OUT1 (bit 2) on bit 6, DTR (bit 0) on bit 5 and RTS (bit 1) on bit 4, with bits 3:0 zero. This read does not clear the stored change flags.
- R6: A control write (`reg_sel`=0, `reg_wr`=1) stores `reg_wdata[4:0]`. The fields are DTR bit 0, RTS bit 1, OUT1 bit 2, OUT2 bit 3 and loopback bit 4. A control read returns them with bits 7:5 zero.
- R7: `out_dtr` and `out_rts` follow control bits 0 and 1 in MODE_LIVE and are 0 in MODE_LOOP. `out_out1` and `out_out2` follow bits 2 and 3 in both modes.
- R8: A line change in the same cycle as a live status read sets its flag, and the flag survives the clear.
- R9: `delta_any` is 1 exactly when any stored change flag is set.
- R10: In MODE_LOOP the input lines do not alter the stored levels or flags. After the return to MODE_LIVE, the first sample is compared with the levels held before loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 5 | Write data for the control register |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| line_cts | input | 1 | Clear-to-send input level |
| line_dsr | input | 1 | Data-set-ready input level |
| line_dcd | input | 1 | Carrier-detect input level |
| line_ri | input | 1 | Ring-indicator input level |
| out_dtr | output | 1 | Data-terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_out1 | output | 1 | General-purpose output 1 |
| out_out2 | output | 1 | General-purpose output 2 |
| delta_any | output | 1 | Any change flag pending |

## Verification
The directed part of the bench applies single-line drops and simultaneous multi-line drops, which tell the per-line flag mapping apart. A ring rise is followed by a ring fall, which separates trailing-edge detection from plain change detection. A line change placed in the cycle of a status read shows whether the clear wins over the new flag. Changes made while in loopback, before a pending flag is read out, show whether loopback freezes the stored state and whether the return to live compares against the held levels. A long random mix of line toggles, reads and control writes, including mode flips, is then compared every cycle against a behavioural model.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    typedef enum logic {
        MODE_LIVE = 1'b0,
        MODE_LOOP = 1'b1
    } mdm_mode_e;

    // positions inside the 4-bit line level / change vectors
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // positions inside the control register
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
#(
    parameter int         CTRL_W   = 5,
    parameter logic [4:0] CTRL_RST = 5'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    output mdm_mode_e         mode,
    output logic [CTRL_W-2:0] ctrl_bits,
    output logic              pin_dtr,
    output logic              pin_rts,
    output logic              pin_out1,
    output logic              pin_out2
);
    localparam int BITS_W = CTRL_W - 1;

    mdm_mode_e         mode_q, mode_nxt;
    logic [BITS_W-1:0] bits_q;

    // next mode
    always_comb begin
        mode_nxt = mode_q;
        if (wr_ctrl) begin
            unique case (mode_q)
                MODE_LIVE: if (wdata[CB_LOOP])  mode_nxt = MODE_LOOP;
                MODE_LOOP: if (!wdata[CB_LOOP]) mode_nxt = MODE_LIVE;
                default:                        mode_nxt = MODE_LIVE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CTRL_RST[CB_LOOP] ? MODE_LOOP : MODE_LIVE;
            bits_q <= CTRL_RST[BITS_W-1:0];
        end else begin
            mode_q <= mode_nxt;
            if (wr_ctrl) bits_q <= wdata[BITS_W-1:0];
        end
    end

    // outputs
    always_comb begin
        pin_out1 = bits_q[CB_OUT1];
        pin_out2 = bits_q[CB_OUT2];
        unique case (mode_q)
            MODE_LIVE: begin
                pin_dtr = bits_q[CB_DTR];
                pin_rts = bits_q[CB_RTS];
            end
            MODE_LOOP: begin
                pin_dtr = 1'b0;
                pin_rts = 1'b0;
            end
            default: begin
                pin_dtr = 1'b0;
                pin_rts = 1'b0;
            end
        endcase
    end

    assign mode      = mode_q;
    assign ctrl_bits = bits_q;
endmodule

// File: rtl/mdm_status_track.sv
module mdm_status_track
    import mdm_pkg::*;
#(
    parameter int         NLINES    = 4,
    parameter logic [3:0] LINES_RST = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_en,
    input  logic              clr_delta,
    input  logic [NLINES-1:0] lines_in,
    output logic [NLINES-1:0] lines_q,
    output logic [NLINES-1:0] delta_q
);
    logic [NLINES-1:0] diff;
    logic [NLINES-1:0] set_mask;
    logic [NLINES-1:0] keep;

    assign diff = lines_in ^ lines_q;

    // ring flag only on trailing edge; other lines on any change
    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_set
            if (i == LN_RI) begin : g_trail
                assign set_mask[i] = diff[i] & lines_q[i];
            end else begin : g_any
                assign set_mask[i] = diff[i];
            end
        end
    endgenerate

    assign keep = clr_delta ? '0 : delta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= LINES_RST[NLINES-1:0];
            delta_q <= '0;
        end else if (track_en) begin
            lines_q <= lines_in;
            delta_q <= keep | set_mask;
        end
    end
endmodule

// File: rtl/mdm_read_mux.sv
module mdm_read_mux
    import mdm_pkg::*;
#(
    parameter int CTRL_W = 5,
    parameter int NLINES = 4
) (
    input  logic              sel_status,
    input  mdm_mode_e         mode,
    input  logic [CTRL_W-2:0] ctrl_bits,
    input  logic [NLINES-1:0] lines_q,
    input  logic [NLINES-1:0] delta_q,
    output logic [7:0]        rdata
);
    logic [NLINES-1:0] loop_lines;

    always_comb begin
        loop_lines          = '0;
        loop_lines[LN_DCD]  = ctrl_bits[CB_OUT2];
        loop_lines[LN_RI]   = ctrl_bits[CB_OUT1];
        loop_lines[LN_DSR]  = ctrl_bits[CB_DTR];
        loop_lines[LN_CTS]  = ctrl_bits[CB_RTS];
    end

    always_comb begin
        if (!sel_status) begin
            rdata = {3'b000, (mode == MODE_LOOP), ctrl_bits};
        end else begin
            unique case (mode)
                MODE_LIVE: rdata = {lines_q, delta_q};
                MODE_LOOP: rdata = {loop_lines, 4'h0};
                default:   rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import mdm_pkg::*;
#(
    parameter int         CTRL_W    = 5,
    parameter int         NLINES    = 4,
    parameter logic [4:0] CTRL_RST  = 5'h08,
    parameter logic [3:0] LINES_RST = 4'hB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_dcd,
    input  logic              line_ri,
    output logic              out_dtr,
    output logic              out_rts,
    output logic              out_out1,
    output logic              out_out2,
    output logic              delta_any
);
    mdm_mode_e         mode;
    logic [CTRL_W-2:0] ctrl_bits;
    logic [NLINES-1:0] lines_in;
    logic [NLINES-1:0] lines_q;
    logic [NLINES-1:0] delta_q;
    logic              loop_on;
    logic              wr_ctrl;
    logic              clr_delta;

    assign loop_on   = (mode == MODE_LOOP);
    assign wr_ctrl   = reg_wr && !reg_sel;
    assign clr_delta = reg_rd && reg_sel && !loop_on;

    always_comb begin
        lines_in         = '0;
        lines_in[LN_CTS] = line_cts;
        lines_in[LN_DSR] = line_dsr;
        lines_in[LN_RI]  = line_ri;
        lines_in[LN_DCD] = line_dcd;
    end

    mdm_ctrl_reg #(.CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata),
        .mode     (mode),
        .ctrl_bits(ctrl_bits),
        .pin_dtr  (out_dtr),
        .pin_rts  (out_rts),
        .pin_out1 (out_out1),
        .pin_out2 (out_out2)
    );

    mdm_status_track #(.NLINES(NLINES), .LINES_RST(LINES_RST)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .track_en (!loop_on),
        .clr_delta(clr_delta),
        .lines_in (lines_in),
        .lines_q  (lines_q),
        .delta_q  (delta_q)
    );

    mdm_read_mux #(.CTRL_W(CTRL_W), .NLINES(NLINES)) u_rmux (
        .sel_status(reg_sel),
        .mode      (mode),
        .ctrl_bits (ctrl_bits),
        .lines_q   (lines_q),
        .delta_q   (delta_q),
        .rdata     (reg_rdata)
    );

    assign delta_any = |delta_q;
endmodule

// File: rtl/modem_status_unit_chk.sv
module modem_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_rd,
    input logic       reg_sel,
    input logic       loop_on,
    input logic [3:0] lines_q,
    input logic [3:0] delta_q,
    input logic       out_rts,
    input logic       out_dtr
);
    AST_TERI_TRAILING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[2]) |-> ($past(lines_q[2]) && !lines_q[2]));  // R3

    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (!out_rts && !out_dtr));  // R7

    AST_READ_CLEARS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel && !loop_on) |=> ((delta_q & ~($past(lines_q) ^ lines_q)) == 4'h0));  // R4

    AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel && !loop_on) |=> ((($past(lines_q) ^ lines_q) & 4'b1011 & ~delta_q) == 4'h0));  // R8

    AST_LOOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_on) |-> ($stable(lines_q) && $stable(delta_q)));  // R10

    AST_LOOP_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel && loop_on) |=> $stable(delta_q));  // R5
endmodule

bind modem_status_unit modem_status_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_rd  (reg_rd),
    .reg_sel (reg_sel),
    .loop_on (loop_on),
    .lines_q (lines_q),
    .delta_q (delta_q),
    .out_rts (out_rts),
    .out_dtr (out_dtr)
);

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_rd, reg_wr, reg_sel;
    logic [4:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       line_cts, line_dsr, line_dcd, line_ri;
    logic       out_dtr, out_rts, out_out1, out_out2, delta_any;

    always #5 clk = ~clk;

    modem_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd),
        .line_ri(line_ri), .out_dtr(out_dtr), .out_rts(out_rts),
        .out_out1(out_out1), .out_out2(out_out2), .delta_any(delta_any)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] last_rd;

    // behavioural reference state
    logic [4:0] m_ctrl;
    logic [3:0] m_lines;   // {dcd, ri, dsr, cts}
    logic [3:0] m_delta;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic sel);
        if (!sel) return {3'b000, m_ctrl};
        if (m_ctrl[4]) return {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1], 4'h0};
        return {m_lines, m_delta};
    endfunction

    // one clock: drive, compare, clock, update model
    task automatic step(input logic rd, input logic wr, input logic sel,
                        input logic [4:0] wd, input logic [3:0] ln);
        logic [3:0] chg;
        logic [3:0] setm;
        reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        line_dcd = ln[3]; line_ri = ln[2]; line_dsr = ln[1]; line_cts = ln[0];
        #1;
        last_rd = reg_rdata;
        if (sel) check(m_ctrl[4] ? "R5 loop status read" : "R4 live status read", reg_rdata, model_rd(1'b1));
        else     check("R6 control read", reg_rdata, model_rd(1'b0));
        check("R7 output pins", {4'h0, out_out2, out_out1, out_rts, out_dtr},
              {4'h0, m_ctrl[3], m_ctrl[2], m_ctrl[1] & ~m_ctrl[4], m_ctrl[0] & ~m_ctrl[4]});
        check("R9 delta_any", {7'h0, delta_any}, {7'h0, |m_delta});
        @(posedge clk);
        if (!m_ctrl[4]) begin
            chg  = ln ^ m_lines;
            setm = {chg[3], chg[2] & m_lines[2], chg[1], chg[0]};
            m_delta = ((rd && sel) ? 4'h0 : m_delta) | setm;
            m_lines = ln;
        end
        if (wr && !sel) m_ctrl = wd;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        reg_rd = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        line_dcd = 1; line_ri = 0; line_dsr = 1; line_cts = 1;
        m_ctrl = 5'h08; m_lines = 4'hB; m_delta = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        step(0, 0, 1, 0, 4'b1011); check("R1 status after reset", last_rd, 8'hB0);
        step(0, 0, 0, 0, 4'b1011); check("R1 control after reset", last_rd, 8'h08);

        // R2 single line drop, R4 clear on read
        step(0, 0, 1, 0, 4'b1010);
        step(1, 0, 1, 0, 4'b1010); check("R2 cts drop", last_rd, 8'hA1);
        step(1, 0, 1, 0, 4'b1010); check("R4 flags cleared", last_rd, 8'hA0);

        // R3 ring rise then fall
        step(0, 0, 1, 0, 4'b1110);
        step(1, 0, 1, 0, 4'b1110); check("R3 ring rise no flag", last_rd, 8'hE0);
        step(0, 0, 1, 0, 4'b1010);
        step(1, 0, 1, 0, 4'b1010); check("R3 ring fall sets flag", last_rd, 8'hA4);

        // R2 two lines at once
        step(0, 0, 1, 0, 4'b0000);
        step(1, 0, 1, 0, 4'b0000); check("R2 dcd+dsr drop", last_rd, 8'h0A);

        // R8 change in the read cycle
        step(1, 0, 1, 0, 4'b0001); check("R8 read during change", last_rd, 8'h00);
        step(1, 0, 1, 0, 4'b0001); check("R8 new flag kept", last_rd, 8'h11);

        // R6 control write
        step(0, 1, 0, 5'h03, 4'b0001);
        step(0, 0, 0, 0, 4'b0001); check("R6 control stored", last_rd, 8'h03);

        // R10 loopback freeze with a pending flag
        step(0, 0, 1, 0, 4'b0000);                 // cts falls -> flag bit0
        step(0, 1, 0, 5'h1D, 4'b0000);             // enter loop
        step(1, 0, 1, 0, 4'b1111); check("R5 loop mapping", last_rd, 8'hE0);
        step(1, 0, 1, 0, 4'b0101);
        step(0, 0, 0, 0, 4'b1111); check("R6 loop bit readback", last_rd, 8'h1D);
        step(0, 1, 0, 5'h03, 4'b1111);             // leave loop
        step(1, 0, 1, 0, 4'b1111); check("R10 held through loop", last_rd, 8'h01);
        step(1, 0, 1, 0, 4'b1111); check("R10 compare to held", last_rd, 8'hFB);

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic wr_r;
            wr_r = ($urandom_range(0, 7) == 0);
            step($urandom_range(0, 1), wr_r, wr_r ? 1'b0 : 1'($urandom_range(0, 1)),
                 5'($urandom_range(0, 31)), 4'($urandom_range(0, 15)));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule